// File: doc/BRIEF.md
# Memory-mapped mesh network interface

This block sits between a processor's simple bus and the local port of a two-dimensional mesh router. To software, the network looks like memory. A write to a network address turns into a one-word packet on the router's injection port. The write data becomes the payload. The address bits carry the destination column, the destination row and the first hop direction. A read from a network address hands back the payload of the oldest packet that the router has delivered to this node.

All flow control appears as bus wait states. A write waits while the router refuses new packets. A read waits while nothing has arrived. A status word at a reserved address answers at once. It reports how many packets are waiting and whether the injection port is refusing traffic. Arriving packets are held in a small first-in first-out queue until software reads them.

Top module: `mesh_ni`

## Requirements
- R1: A bus cycle (`bus_req`=1) with `bus_addr[ADDR_W-1]`=0 and `bus_we`=1 drives `inj_valid`=1 in the same cycle. The transfer completes at the first rising edge where `bus_ready` is 1.
- R2: The packet on `inj_pkt` is laid out from the least significant bit upward as follows:
  - the payload, equal to `bus_wdata`, in bits [DATA_W-1:0];
  - a 2-bit direction equal to `bus_addr[1:0]` (00 north, 01 east, 10 south, 11 west);
  - the 4-bit destination X, equal to `bus_addr[5:2]`;
  - the 4-bit destination Y, equal to `bus_addr[9:6]`.
- R3: While `inj_ready` is 0, a network write holds `bus_ready` at 0 and keeps `inj_valid` at 1. `bus_ready` rises in the cycle `inj_ready` rises.
- R4: Network reads (`bus_we`=0, `bus_addr[ADDR_W-1]`=0) return delivered payloads on `bus_rdata` in arrival order.
- R5: A network read with no packet waiting holds `bus_ready` at 0. `bus_ready` becomes 1, with the new payload, in the cycle after the rising edge where the router hands over a packet.
- R6: The queue holds 4 packets. While it is full, `ej_ready` is 0 and a delivery offered on `ej_valid` is not taken.
- R7: A read with `bus_addr[ADDR_W-1]`=1 has `bus_ready`=1 in the same cycle. It returns the waiting-packet count in bits [7:0] and, in bit 8, a 1 when `inj_ready` is 0. All other bits are 0.
- R8: A write with `bus_addr[ADDR_W-1]`=1 completes at once and launches no packet.
- R9: With `bus_req`=0, `bus_ready` and `inj_valid` are 0. After reset the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus cycle request, held until ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address; top bit selects the status word |
| bus_wdata | input | DATA_W | Write data (payload) |
| bus_rdata | output | DATA_W | Read data |
| bus_ready | output | 1 | Cycle completes on this edge when 1 |
| inj_valid | output | 1 | Packet offered to the router |
| inj_ready | input | 1 | Router accepts the offered packet |
| inj_pkt | output | PKT_W | Packet {Y, X, direction, payload} |
| ej_valid | input | 1 | Router delivers a packet to this node |
| ej_ready | output | 1 | Node can take a delivered packet |
| ej_data | input | DATA_W | Delivered payload |

## Verification
The bench uses the default parameters: 32-bit data, 4-bit coordinates, a 12-bit address and a four-entry queue. The narrow coordinate fields allow a full sweep of every direction, X and Y combination, which is 1024 distinct packets. The shallow queue allows every fill level from one to full to be reached repeatedly. This drives the read and write pointers through several wrap-arounds and covers the full-queue refusal.

// File: rtl/mesh_ni_pkg.sv
package mesh_ni_pkg;

    localparam int NI_DATA_W  = 32;
    localparam int NI_COORD_W = 4;
    localparam int NI_ADDR_W  = 12;
    localparam int NI_DEPTH   = 4;

    // status word layout
    localparam int STAT_CNT_W    = 8;
    localparam int STAT_BUSY_BIT = 8;

    typedef enum logic [1:0] {
        HOP_NORTH = 2'b00,
        HOP_EAST  = 2'b01,
        HOP_SOUTH = 2'b10,
        HOP_WEST  = 2'b11
    } hop_dir_e;

    function automatic int pkt_width(int data_w, int coord_w);
        return data_w + 2 + 2 * coord_w;
    endfunction

endpackage

// File: rtl/mesh_ni_txfmt.sv
module mesh_ni_txfmt
    import mesh_ni_pkg::*;
#(
    parameter int DATA_W  = NI_DATA_W,
    parameter int COORD_W = NI_COORD_W,
    parameter int ADDR_W  = NI_ADDR_W,
    localparam int PKT_W  = pkt_width(DATA_W, COORD_W)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [PKT_W-1:0]  pkt
);
    localparam int X_LSB = 2;
    localparam int Y_LSB = 2 + COORD_W;

    typedef struct packed {
        logic [COORD_W-1:0] dst_y;
        logic [COORD_W-1:0] dst_x;
        hop_dir_e           dir;
        logic [DATA_W-1:0]  payload;
    } pkt_t;

    pkt_t p;

    always_comb begin
        p.dir     = hop_dir_e'(addr[1:0]);
        p.dst_x   = addr[X_LSB +: COORD_W];
        p.dst_y   = addr[Y_LSB +: COORD_W];
        p.payload = wdata;
        pkt       = p;
    end

endmodule

// File: rtl/mesh_ni_rxq.sv
module mesh_ni_rxq #(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign dout  = mem[rd_ptr];
    assign full  = (cnt == CNT_W'(DEPTH));
    assign empty = (cnt == '0);
    assign count = cnt;

endmodule

// File: rtl/mesh_ni.sv
module mesh_ni
    import mesh_ni_pkg::*;
#(
    parameter int DATA_W  = NI_DATA_W,
    parameter int COORD_W = NI_COORD_W,
    parameter int ADDR_W  = NI_ADDR_W,
    parameter int DEPTH   = NI_DEPTH,
    localparam int PKT_W  = pkt_width(DATA_W, COORD_W),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              inj_valid,
    input  logic              inj_ready,
    output logic [PKT_W-1:0]  inj_pkt,
    input  logic              ej_valid,
    output logic              ej_ready,
    input  logic [DATA_W-1:0] ej_data
);
    logic              is_stat;
    logic              q_full, q_empty, q_pop;
    logic [DATA_W-1:0] q_head;
    logic [CNT_W-1:0]  q_count;
    logic [DATA_W-1:0] stat_word;

    assign is_stat = bus_addr[ADDR_W-1];

    mesh_ni_txfmt #(
        .DATA_W (DATA_W),
        .COORD_W(COORD_W),
        .ADDR_W (ADDR_W)
    ) u_txfmt (
        .addr (bus_addr),
        .wdata(bus_wdata),
        .pkt  (inj_pkt)
    );

    mesh_ni_rxq #(
        .W    (DATA_W),
        .DEPTH(DEPTH)
    ) u_rxq (
        .clk  (clk),
        .rst  (rst),
        .push (ej_valid && !q_full),
        .din  (ej_data),
        .pop  (q_pop),
        .dout (q_head),
        .full (q_full),
        .empty(q_empty),
        .count(q_count)
    );

    assign ej_ready  = !q_full;
    assign inj_valid = bus_req && bus_we && !is_stat;
    assign q_pop     = bus_req && !bus_we && !is_stat && !q_empty;

    always_comb begin
        stat_word                = '0;
        stat_word[CNT_W-1:0]     = q_count;
        stat_word[STAT_BUSY_BIT] = !inj_ready;
    end

    always_comb begin
        if (!bus_req)     bus_ready = 1'b0;
        else if (is_stat) bus_ready = 1'b1;
        else if (bus_we)  bus_ready = inj_ready;
        else              bus_ready = !q_empty;
    end

    assign bus_rdata = is_stat ? stat_word : q_head;

endmodule

// File: rtl/mesh_ni_chk.sv
module mesh_ni_chk #(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ready,
    input logic              inj_valid,
    input logic              inj_ready,
    input logic              ej_valid,
    input logic              ej_ready
);
    localparam int MW = $clog2(DEPTH + 1) + 1;

    logic          stat_sel;
    logic          seen_pop;
    logic [MW-1:0] occ;

    assign stat_sel = bus_addr[ADDR_W-1];
    assign seen_pop = bus_req && !bus_we && !stat_sel && bus_ready;

    // occupancy rebuilt from port traffic only
    always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else     occ <= occ + MW'(ej_valid && ej_ready) - MW'(seen_pop);
    end

    assert_write_waits_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && !stat_sel && bus_ready) |-> (inj_valid && inj_ready));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (occ >= MW'(DEPTH)) |-> !ej_ready);

    assert_empty_read_stalls_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && !stat_sel && occ == '0) |-> !bus_ready);

    assert_status_no_wait_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_req && stat_sel) |-> bus_ready);

    assert_status_write_dropped_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && stat_sel) |-> !inj_valid);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_req |-> (!bus_ready && !inj_valid));

endmodule

bind mesh_ni mesh_ni_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_ready(bus_ready),
    .inj_valid(inj_valid),
    .inj_ready(inj_ready),
    .ej_valid (ej_valid),
    .ej_ready (ej_ready)
);

// File: tb/test_mesh_ni.sv
`timescale 1ns/1ps
module test_mesh_ni;
    localparam int DW = 32;
    localparam int AW = 12;
    localparam int PW = 42;
    localparam logic [AW-1:0] STAT_A = 12'h800;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_req = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_ready, inj_valid, ej_ready;
    logic          inj_ready = 1'b1;
    logic [PW-1:0] inj_pkt;
    logic          ej_valid = 1'b0;
    logic [DW-1:0] ej_data = '0;

    int  n_cmp = 0, n_bad = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    mesh_ni i_mesh_ni (
        .clk(clk), .rst(rst),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_pkt(inj_pkt),
        .ej_valid(ej_valid), .ej_ready(ej_ready), .ej_data(ej_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0;
    endtask

    // read status word, expect count and busy
    task automatic read_status(input int cnt, input bit busy, input string req);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = STAT_A;
        #2;
        chk({req, " status ready"}, 64'(bus_ready), 64'd1);
        chk({req, " status word"}, 64'(bus_rdata), 64'((32'(busy) << 8) | 32'(cnt)));
        @(negedge clk); idle();
    endtask

    task automatic deliver(input logic [DW-1:0] d);
        ej_valid = 1'b1; ej_data = d;
        #2;
        chk("R6 ej_ready while not full", 64'(ej_ready), 64'd1);
        @(negedge clk); ej_valid = 1'b0;
    endtask

    task automatic read_net(input logic [DW-1:0] exp, input string req);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 12'h000;
        #2;
        chk({req, " read ready"}, 64'(bus_ready), 64'd1);
        chk({req, " read data"}, 64'(bus_rdata), 64'(exp));
        @(negedge clk); idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: idle outputs and empty queue
        #2;
        chk("R9 idle ready", 64'(bus_ready), 64'd0);
        chk("R9 idle inj_valid", 64'(inj_valid), 64'd0);
        @(negedge clk);
        read_status(0, 1'b0, "R9");

        // R1 R2: sweep every direction, X and Y
        for (int d = 0; d < 4; d++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++) begin
                    logic [AW-1:0] a;
                    logic [DW-1:0] w;
                    a = AW'(y * 64 + x * 4 + d);
                    w = 32'h5A00_0000 ^ (32'(a) * 32'h0001_0203);
                    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = w;
                    #2;
                    chk("R1 inj_valid", 64'(inj_valid), 64'd1);
                    chk("R1 ready", 64'(bus_ready), 64'd1);
                    chk("R2 packet", 64'(inj_pkt),
                        64'({y[3:0], x[3:0], d[1:0], w}));
                    @(negedge clk);
                end
        idle();

        // R7: busy flag reflects the refusing router
        inj_ready = 1'b0;
        read_status(0, 1'b1, "R7");

        // R3: write waits for the router
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h2C7; bus_wdata = 32'hCAFE_0001;
        for (int k = 0; k < 3; k++) begin
            #2;
            chk("R3 stalled ready", 64'(bus_ready), 64'd0);
            chk("R3 held inj_valid", 64'(inj_valid), 64'd1);
            @(negedge clk);
        end
        inj_ready = 1'b1;
        #2;
        chk("R3 ready on accept", 64'(bus_ready), 64'd1);
        chk("R3 packet", 64'(inj_pkt), 64'({4'hB, 4'h1, 2'b11, 32'hCAFE_0001}));
        @(negedge clk); idle();

        // R8: write to the status address
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = STAT_A; bus_wdata = 32'hFFFF_FFFF;
        #2;
        chk("R8 ready", 64'(bus_ready), 64'd1);
        chk("R8 no packet", 64'(inj_valid), 64'd0);
        @(negedge clk); idle();
        read_status(0, 1'b0, "R8");

        // R4 R6: every fill level, several pointer wraps
        for (int round = 0; round < 3; round++)
            for (int n = 1; n <= 4; n++) begin
                for (int i = 0; i < n; i++)
                    deliver(32'h1000_0000 + 32'(round * 256 + n * 16 + i));
                read_status(n, 1'b0, "R4");
                if (n == 4) begin
                    ej_valid = 1'b1; ej_data = 32'hDEAD_BEEF;
                    #2;
                    chk("R6 full refuses", 64'(ej_ready), 64'd0);
                    @(negedge clk); ej_valid = 1'b0;
                    read_status(4, 1'b0, "R6");
                end
                for (int i = 0; i < n; i++)
                    read_net(32'h1000_0000 + 32'(round * 256 + n * 16 + i), "R4");
                read_status(0, 1'b0, "R4");
            end

        // R5: read waits for an arrival
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 12'h000;
        for (int k = 0; k < 3; k++) begin
            #2;
            chk("R5 empty stall", 64'(bus_ready), 64'd0);
            @(negedge clk);
        end
        ej_valid = 1'b1; ej_data = 32'h0BAD_F00D;
        #2;
        chk("R5 still waiting at push edge", 64'(bus_ready), 64'd0);
        @(negedge clk); ej_valid = 1'b0;
        #2;
        chk("R5 ready after arrival", 64'(bus_ready), 64'd1);
        chk("R5 data", 64'(bus_rdata), 64'h0BAD_F00D);
        @(negedge clk); idle();
        read_status(0, 1'b0, "R5");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule